// File: doc/BRIEF.md
# Command-Gated Memory Bank Select Decoder

This block turns a byte address and a pair of read/write commands into the control signals for a memory built from several equal banks. The default build has a 20-bit address and eight banks of 128K bytes each, which gives 1 MB. The address is split into a 3-bit bank index and a 17-bit offset inside the bank. The index is decoded into eight active-low bank selects. The offset and the active-low write and output enables are shared by all banks. The bank storage and the data bus lie outside the block.

A build-time parameter chooses how addresses map to banks. In contiguous mapping (`INTERLEAVE = 0`) the high index bits choose the bank, so each bank holds one unbroken region. In interleaved mapping (`INTERLEAVE = 1`) the low index bits choose the bank, so consecutive bytes fall in consecutive banks. The selects are driven only while a read or a write command is present. If both commands are asserted together, the block raises an error flag and performs the access as a write.

The inputs are captured in a small access-state register. It has four states: `ACC_IDLE` (no command), `ACC_READ` (read only), `ACC_WRITE` (write only) and `ACC_CLASH` (read and write together). The register may move from any state to any other on each clock, following the command pair seen at that edge. Reset puts it in `ACC_IDLE`. Every output is decoded from this register, so each output reflects the inputs sampled at the previous rising edge.

Top module: `mbd_bank_decoder`

## Requirements
- R1: While reset is asserted and right after it, every bank select, `wr_en_n` and `out_en_n` are 1 and `cmd_err` is 0.
- R2: In contiguous mapping, a command sampled with address bits 19..17 equal to k drives `bank_sel_n[k]` to 0 one clock later, and drives all other selects to 1.
- R3: In contiguous mapping, `bank_addr` equals address bits 16..0 sampled one clock earlier.
- R4: In interleaved mapping, a command sampled with address bits 2..0 equal to k drives `bank_sel_n[k]` to 0 one clock later, and drives all other selects to 1.
- R5: In interleaved mapping, `bank_addr` equals address bits 19..3 sampled one clock earlier.
- R6: When neither command was sampled, all selects are 1, both enables are 1 and `cmd_err` is 0, whatever the address. No bank can respond.
- R7: A sampled read without a write gives `out_en_n` = 0, `wr_en_n` = 1 and `cmd_err` = 0.
- R8: A sampled write without a read gives `wr_en_n` = 0, `out_en_n` = 1 and `cmd_err` = 0.
- R9: A sampled read and write together give `cmd_err` = 1, `wr_en_n` = 0 and `out_en_n` = 1, with the addressed bank selected.
- R10: At most one bank select is 0 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W (20) | Byte address |
| rd_cmd | input | 1 | Read command, active high |
| wr_cmd | input | 1 | Write command, active high |
| bank_sel_n | output | 2**BANK_BITS (8) | Per-bank select, active low |
| bank_addr | output | ADDR_W-BANK_BITS (17) | Offset inside the selected bank |
| wr_en_n | output | 1 | Shared write enable, active low |
| out_en_n | output | 1 | Shared output enable, active low |
| cmd_err | output | 1 | Read and write asserted together |

## Verification
A wrong access state shows up at the ports one clock after the command is sampled. It appears as a select active while no command is present, as the wrong enable low, or as an error flag that disagrees with the command pair. A wrong bank index or offset register shows up in the same cycle as a select on the wrong bank or a wrong `bank_addr`. Both mappings are driven with the same address sequence, and the sequence includes the bank boundary addresses, so a swapped bit field changes the expected bank at once. Because every output is recomputed each cycle, a fault stays visible only until the next command overwrites it. Each result is therefore compared in the cycle it belongs to.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_CLASH = 2'd3
    } acc_state_e;

endpackage

// File: rtl/mbd_cmd_class.sv
module mbd_cmd_class
    import mbd_pkg::*;
(
    input  logic       rd,
    input  logic       wr,
    output acc_state_e kind
);
    always_comb begin
        unique case ({wr, rd})
            2'b00:   kind = ACC_IDLE;
            2'b01:   kind = ACC_READ;
            2'b10:   kind = ACC_WRITE;
            default: kind = ACC_CLASH;
        endcase
    end
endmodule

// File: rtl/mbd_addr_split.sv
module mbd_addr_split #(
    parameter int ADDR_W     = 20,
    parameter int BANK_BITS  = 3,
    parameter bit INTERLEAVE = 1'b0,
    localparam int OFF_W     = ADDR_W - BANK_BITS
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [BANK_BITS-1:0] bank_idx,
    output logic [OFF_W-1:0]     offset
);
    generate
        if (INTERLEAVE) begin : g_low_order
            assign bank_idx = addr[BANK_BITS-1:0];
            assign offset   = addr[ADDR_W-1:BANK_BITS];
        end else begin : g_high_order
            assign bank_idx = addr[ADDR_W-1:OFF_W];
            assign offset   = addr[OFF_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/mbd_low_decode.sv
module mbd_low_decode #(
    parameter int IDX_W   = 3,
    localparam int OUT_W  = 1 << IDX_W
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [OUT_W-1:0] sel_n
);
    generate
        for (genvar k = 0; k < OUT_W; k++) begin : g_line
            assign sel_n[k] = !(en && (idx == IDX_W'(k)));
        end
    endgenerate
endmodule

// File: rtl/mbd_bank_decoder.sv
module mbd_bank_decoder
    import mbd_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int BANK_BITS   = 3,
    parameter bit INTERLEAVE  = 1'b0,
    localparam int NUM_BANKS  = 1 << BANK_BITS,
    localparam int OFF_W      = ADDR_W - BANK_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd_cmd,
    input  logic                 wr_cmd,
    output logic [NUM_BANKS-1:0] bank_sel_n,
    output logic [OFF_W-1:0]     bank_addr,
    output logic                 wr_en_n,
    output logic                 out_en_n,
    output logic                 cmd_err
);
    acc_state_e             state_q, state_d;
    logic [BANK_BITS-1:0]   idx_d, idx_q;
    logic [OFF_W-1:0]       off_d, off_q;
    logic                   dec_en;

    mbd_cmd_class u_class (
        .rd   (rd_cmd),
        .wr   (wr_cmd),
        .kind (state_d)
    );

    mbd_addr_split #(
        .ADDR_W     (ADDR_W),
        .BANK_BITS  (BANK_BITS),
        .INTERLEAVE (INTERLEAVE)
    ) u_split (
        .addr     (addr),
        .bank_idx (idx_d),
        .offset   (off_d)
    );

    // state register: access kind plus captured address fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            idx_q   <= '0;
            off_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            off_q   <= off_d;
        end
    end

    // output decode from the access state
    always_comb begin
        dec_en   = 1'b0;
        wr_en_n  = 1'b1;
        out_en_n = 1'b1;
        cmd_err  = 1'b0;
        unique case (state_q)
            ACC_IDLE: ;
            ACC_READ: begin
                dec_en   = 1'b1;
                out_en_n = 1'b0;
            end
            ACC_WRITE: begin
                dec_en  = 1'b1;
                wr_en_n = 1'b0;
            end
            ACC_CLASH: begin
                dec_en  = 1'b1;
                wr_en_n = 1'b0;
                cmd_err = 1'b1;
            end
            default: ;
        endcase
    end

    mbd_low_decode #(.IDX_W(BANK_BITS)) u_decode (
        .en    (dec_en),
        .idx   (idx_q),
        .sel_n (bank_sel_n)
    );

    assign bank_addr = off_q;
endmodule

// File: rtl/mbd_bank_decoder_chk.sv
module mbd_bank_decoder_chk #(
    parameter int NUM_BANKS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rd_cmd,
    input logic                 wr_cmd,
    input logic [NUM_BANKS-1:0] bank_sel_n,
    input logic                 wr_en_n,
    input logic                 out_en_n,
    input logic                 cmd_err
);
    // R10
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~bank_sel_n) <= 1);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_cmd && !wr_cmd) |=> (&bank_sel_n && wr_en_n && out_en_n && !cmd_err));

    // R7
    read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && !wr_cmd) |=> (!out_en_n && wr_en_n && !cmd_err
                                 && $countones(~bank_sel_n) == 1));

    // R8
    write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !rd_cmd) |=> (!wr_en_n && out_en_n && !cmd_err
                                 && $countones(~bank_sel_n) == 1));

    // R9
    clash_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && rd_cmd) |=> (cmd_err && !wr_en_n && out_en_n
                                && $countones(~bank_sel_n) == 1));
endmodule

bind mbd_bank_decoder mbd_bank_decoder_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_cmd     (rd_cmd),
    .wr_cmd     (wr_cmd),
    .bank_sel_n (bank_sel_n),
    .wr_en_n    (wr_en_n),
    .out_en_n   (out_en_n),
    .cmd_err    (cmd_err)
);

// File: tb/test_mbd_bank_decoder.sv
`timescale 1ns/1ps
module test_mbd_bank_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        rd_cmd = 1'b0;
    logic        wr_cmd = 1'b0;

    logic [7:0]  sel_c, sel_i;
    logic [16:0] off_c, off_i;
    logic        we_c, oe_c, err_c, we_i, oe_i, err_i;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0]  sel_c;
        logic [16:0] off_c;
        logic [7:0]  sel_i;
        logic [16:0] off_i;
        logic        we_n;
        logic        oe_n;
        logic        err;
        logic [1:0]  kind;
    } exp_t;

    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    mbd_bank_decoder #(.INTERLEAVE(1'b0)) i_mbd_bank_decoder (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
        .bank_sel_n(sel_c), .bank_addr(off_c), .wr_en_n(we_c),
        .out_en_n(oe_c), .cmd_err(err_c)
    );

    mbd_bank_decoder #(.INTERLEAVE(1'b1)) i_mbd_bank_decoder_ilv (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
        .bank_sel_n(sel_i), .bank_addr(off_i), .wr_en_n(we_i),
        .out_en_n(oe_i), .cmd_err(err_i)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // driver: apply one access and queue what the ports must show next cycle
    task automatic drive(input logic [19:0] a, input logic rd, input logic wr);
        exp_t e;
        logic en;
        @(negedge clk);
        addr = a; rd_cmd = rd; wr_cmd = wr;
        en = rd | wr;
        e.sel_c = en ? ~(8'd1 << a[19:17]) : 8'hFF;
        e.sel_i = en ? ~(8'd1 << a[2:0])   : 8'hFF;
        e.off_c = a[16:0];
        e.off_i = a[19:3];
        e.we_n  = ~wr;
        e.oe_n  = ~(rd & ~wr);
        e.err   = rd & wr;
        e.kind  = {wr, rd};
        sb_q.push_back(e);
    endtask

    // monitor: compare one queued item per cycle, after the capturing edge
    initial begin
        exp_t e;
        string tsel, ten;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                unique case (e.kind)
                    2'b00: begin tsel = "R6"; ten = "R6"; end
                    2'b01: begin tsel = "R2"; ten = "R7"; end
                    2'b10: begin tsel = "R2"; ten = "R8"; end
                    default: begin tsel = "R2"; ten = "R9"; end
                endcase
                check(tsel, {24'd0, sel_c}, {24'd0, e.sel_c});
                check((e.kind == 2'b00) ? "R6" : "R4", {24'd0, sel_i}, {24'd0, e.sel_i});
                check("R3", {15'd0, off_c}, {15'd0, e.off_c});
                check("R5", {15'd0, off_i}, {15'd0, e.off_i});
                check(ten, {30'd0, we_c, oe_c}, {30'd0, e.we_n, e.oe_n});
                check(ten, {30'd0, we_i, oe_i}, {30'd0, e.we_n, e.oe_n});
                check("R9", {31'd0, err_c}, {31'd0, e.err});
                check("R10", (($countones(~sel_c) <= 1) ? 32'd1 : 32'd0), 32'd1);
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // R1: outputs during reset and just after release
        repeat (3) @(posedge clk);
        #1;
        check("R1", {24'd0, sel_c}, 32'h0000_00FF);
        check("R1", {29'd0, we_c, oe_c, err_c}, 32'd6);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1", {24'd0, sel_i}, 32'h0000_00FF);
        check("R1", {29'd0, we_i, oe_i, err_i}, 32'd6);

        // R6: addresses with no command
        drive(20'hFFFFF, 1'b0, 1'b0);
        drive(20'h20000, 1'b0, 1'b0);
        // R2 R3 R7: read the first and last byte of each contiguous bank
        for (int k = 0; k < 8; k++) begin
            drive(20'(k) << 17, 1'b1, 1'b0);
            drive((20'(k) << 17) | 20'h1FFFF, 1'b1, 1'b0);
        end
        // R4 R5 R8: write consecutive bytes across the interleaved banks
        for (int k = 0; k < 16; k++) drive(20'h12340 + 20'(k), 1'b0, 1'b1);
        // R9: read and write together
        drive(20'hA5A5A, 1'b1, 1'b1);
        drive(20'h00007, 1'b1, 1'b1);
        // mixed sequence, including idle between accesses
        drive(20'h5_0003, 1'b1, 1'b0);
        drive(20'h5_0003, 1'b0, 1'b0);
        drive(20'hE_FFF9, 1'b0, 1'b1);
        drive(20'h1FFFF, 1'b1, 1'b0);
        drive(20'h00000, 1'b0, 1'b0);
        @(negedge clk);
        rd_cmd = 1'b0; wr_cmd = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R10", {31'd0, (sb_q.size() == 0)}, 32'd1);
        finish_run();
    end
endmodule